// File: doc/BRIEF.md
# Masked Local-Bus Interrupt Aggregator

This block collects up to sixteen level-sensitive interrupt request lines from local-bus devices and merges them into a single interrupt towards the CPU. A source register samples the request lines on every clock, so each bit tracks the level of its line. A 16-bit enable mask, which software can read and write, selects which sources may reach the CPU. A source that is both set and enabled is pending. The combined output is high while any source is pending.

Software finds the source to service by reading a vector register. The vector holds the index of the lowest-numbered pending source plus one, shifted left by two bits, so it can be used directly as a word offset into a handler table. The value zero means nothing is pending. The register window is 16 bits wide and has two defined halfwords. Byte accesses select one lane of a halfword. A 32-bit access covers the halfword at the given address and the one after it.

Top module: `lbus_irq_agg`

## Requirements
- R1: Each source bit takes the level of its request line at every clock edge. It is 1 while the line is high and 0 once the line has gone low, with no latching of past requests.
- R2: `irq_o` is high exactly when (source AND mask) is nonzero. A change on a request line or in the mask shows on `irq_o` after the next rising clock edge.
- R3: A read of halfword offset 0x00 returns ((i+1) << 2), where i is the lowest-numbered pending source. Lower indices win over higher ones. The read returns 0 when nothing is pending.
- R4: Halfword offset 0x02 holds the 16-bit enable mask. A halfword write (size code 1) replaces the mask with `bus_wdata_i[15:0]`, and a halfword read returns it in `bus_rdata_o[15:0]`.
- R5: During and after a synchronous active-low reset, the mask is 0x0010 and the source register is 0, so `irq_o` is low. This holds even if request lines are high during reset.
- R6: A byte access (size code 0) uses address bit 0 to pick a lane: 0 selects bits 7:0 and 1 selects bits 15:8. A byte write to the mask takes `bus_wdata_i[7:0]` into the selected lane and keeps the other lane. A byte read returns the selected lane in `bus_rdata_o[7:0]`.
- R7: A word access (size code 2 or 3) at halfword address h covers h and h+1. A read returns {half(h+1), half(h)}. A write puts `bus_wdata_i[15:0]` at h and `bus_wdata_i[31:16]` at h+1.
- R8: Writes to offset 0x00 and to undefined offsets change nothing. Reads of undefined offsets return 0, and unused upper bits of `bus_rdata_o` read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_lvl_i | input | NUM_SRC | Level-sensitive device request lines |
| bus_we_i | input | 1 | Write strobe, acted on at the rising edge |
| bus_addr_i | input | ADDR_W | Byte offset within the register window |
| bus_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| bus_wdata_i | input | 32 | Write data, right-aligned for byte and halfword |
| bus_rdata_o | output | 32 | Read data for the current address and size (combinational) |
| irq_o | output | 1 | Combined interrupt to the CPU |

## Verification
A wrong source bit or mask bit shows up at the ports one clock after the stimulus that caused it. It appears either as a wrong level on `irq_o` or as a wrong vector on the next read, because both are taken straight from the stored state with no extra register stage. A corrupted mask can also be read back through the window directly, so every mask write is followed by a read-back. Priority faults only appear when several sources are pending at once, so the sweeps pair every single enabled source with every single active line and add random multi-bit patterns.

// File: rtl/lbirq_pkg.sv
// Package: shared widths and the access-size encoding of the register window.
package lbirq_pkg;
    localparam int REG_W = 16;
    localparam int BUS_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WORD_ALT = 2'd3
    } acc_size_e;
endpackage

// File: rtl/lbirq_level_track.sv
// Module: lbirq_level_track
// Samples the device request lines into the source register every clock.
// Assumes the lines are already synchronous to clk.
module lbirq_level_track #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] lvl_i,
    output logic [NUM_SRC-1:0] src_o
);
    logic [NUM_SRC-1:0] src_q;

    // Level capture: each bit follows its line, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= lvl_i;
    end

    assign src_o = src_q;

    assert_src_follows_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (src_q == $past(lvl_i)));
endmodule

// File: rtl/lbirq_lowest_enc.sv
// Module: lbirq_lowest_enc
// Converts the pending bitmap into the vector value ((lowest index + 1) << 2),
// or 0 when no bit is set. Purely combinational.
module lbirq_lowest_enc #(
    parameter int W = 16
) (
    input  logic [W-1:0] pend_i,
    output logic         any_o,
    output logic [W-1:0] vec_o
);
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1;

    // Constant function: the bits whose index has bit b set.
    function automatic logic [W-1:0] sel_mask(input int b);
        logic [W-1:0] m;
        m = '0;
        for (int i = 0; i < W; i++) begin
            m[i] = ((i >> b) & 1) == 1;
        end
        return m;
    endfunction

    logic [W-1:0]   iso;
    logic [IDX_W-1:0] idx;
    logic [IDX_W:0] idx_p1;

    // Isolate the lowest set bit.
    always_comb iso = pend_i & (~pend_i + {{(W-1){1'b0}}, 1'b1});

    // One OR-reduction per index bit, over the positions where that bit is 1.
    for (genvar b = 0; b < IDX_W; b++) begin : g_idx
        localparam logic [W-1:0] SELM = sel_mask(b);
        always_comb idx[b] = |(iso & SELM);
    end

    // Vector formation with the zero case.
    always_comb begin
        any_o  = |pend_i;
        idx_p1 = {1'b0, idx} + {{IDX_W{1'b0}}, 1'b1};
        vec_o  = any_o ? W'({idx_p1, 2'b00}) : '0;
    end
endmodule

// File: rtl/lbirq_regfile.sv
// Module: lbirq_regfile
// Register window: vector at halfword 0 (read-only), mask at halfword 1.
// Handles byte-lane merge and splits word accesses into two halfwords.
// Assumes the whole access completes in one cycle; reads have no side effects.
module lbirq_regfile
    import lbirq_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter logic [REG_W-1:0] MASK_RST = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic [REG_W-1:0]  vec_i,
    output logic [REG_W-1:0]  mask_o,
    output logic [BUS_W-1:0]  rdata_o
);
    localparam int HW_W = ADDR_W - 1;
    localparam logic [HW_W-1:0] HW_VEC  = '0;
    localparam logic [HW_W-1:0] HW_MASK = HW_W'(1);

    logic [REG_W-1:0] mask_q, mask_d;
    logic [HW_W-1:0]  hw_lo, hw_hi;
    logic [REG_W-1:0] half_lo, half_hi;
    logic [7:0]       byte_sel;
    acc_size_e        sz;

    // Halfword selection: the access halfword and its successor.
    always_comb begin
        sz    = acc_size_e'(size_i);
        hw_lo = addr_i[ADDR_W-1:1];
        hw_hi = hw_lo + HW_W'(1);
    end

    function automatic logic [REG_W-1:0] rd_half(input logic [HW_W-1:0] h,
                                                 input logic [REG_W-1:0] vec,
                                                 input logic [REG_W-1:0] msk);
        if (h == HW_VEC)       return vec;
        else if (h == HW_MASK) return msk;
        else                   return '0;
    endfunction

    // Read path: fetch both halves, then shape by size.
    always_comb begin
        half_lo  = rd_half(hw_lo, vec_i, mask_q);
        half_hi  = rd_half(hw_hi, vec_i, mask_q);
        byte_sel = addr_i[0] ? half_lo[15:8] : half_lo[7:0];
        case (sz)
            SZ_BYTE: rdata_o = {24'h0, byte_sel};
            SZ_HALF: rdata_o = {16'h0, half_lo};
            default: rdata_o = {half_hi, half_lo};
        endcase
    end

    // Write path: only the mask is writable; bytes merge with the other lane.
    always_comb begin
        mask_d = mask_q;
        if (we_i) begin
            case (sz)
                SZ_BYTE: begin
                    if (hw_lo == HW_MASK)
                        mask_d = addr_i[0] ? {wdata_i[7:0], mask_q[7:0]}
                                           : {mask_q[15:8], wdata_i[7:0]};
                end
                SZ_HALF: begin
                    if (hw_lo == HW_MASK) mask_d = wdata_i[15:0];
                end
                default: begin
                    if (hw_lo == HW_MASK)      mask_d = wdata_i[15:0];
                    else if (hw_hi == HW_MASK) mask_d = wdata_i[31:16];
                end
            endcase
        end
    end

    // Mask storage with its reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= MASK_RST;
        else        mask_q <= mask_d;
    end

    assign mask_o = mask_q;

    assert_mask_half_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && size_i == 2'd1 && addr_i[ADDR_W-1:1] == HW_MASK)
        |=> (mask_q == $past(wdata_i[15:0])));

    assert_upper_lane_keeps_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && size_i == 2'd0 && addr_i[ADDR_W-1:1] == HW_MASK && addr_i[0])
        |=> (mask_q[7:0] == $past(mask_q[7:0])));

    assert_vector_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && size_i[1] == 1'b0 && addr_i[ADDR_W-1:1] == HW_VEC)
        |=> $stable(mask_q));
endmodule

// File: rtl/lbus_irq_agg.sv
// Module: lbus_irq_agg (top)
// Level-sensitive interrupt aggregator: source tracking, enable masking,
// lowest-index vector and one combined interrupt output.
// Assumes NUM_SRC <= 16 and request lines synchronous to clk.
module lbus_irq_agg
    import lbirq_pkg::*;
#(
    parameter int              NUM_SRC  = 16,
    parameter int              ADDR_W   = 12,
    parameter logic [15:0]     MASK_RST = 16'h0010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_lvl_i,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [1:0]         bus_size_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] src;
    logic [REG_W-1:0]   src_ext, mask, pend, vec;
    logic               any;

    lbirq_level_track #(.NUM_SRC(NUM_SRC)) i_track (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (irq_lvl_i),
        .src_o (src)
    );

    // Pending set: widened sources gated by the mask.
    always_comb begin
        src_ext = REG_W'(src);
        pend    = src_ext & mask;
    end

    lbirq_lowest_enc #(.W(REG_W)) i_enc (
        .pend_i (pend),
        .any_o  (any),
        .vec_o  (vec)
    );

    lbirq_regfile #(.ADDR_W(ADDR_W), .MASK_RST(MASK_RST)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_we_i),
        .addr_i  (bus_addr_i),
        .size_i  (bus_size_i),
        .wdata_i (bus_wdata_i),
        .vec_i   (vec),
        .mask_o  (mask),
        .rdata_o (bus_rdata_o)
    );

    // Combined request to the CPU.
    assign irq_o = any;

    assert_irq_matches_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (vec != '0));

    assert_vector_source_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (vec != '0) |-> ((src_ext & mask) != '0));
endmodule

// File: tb/test_lbus_irq_agg.sv
module test_lbus_irq_agg;
    localparam int NS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] lvl = '0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [1:0]  size = 2'd1;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lbus_irq_agg #(.NUM_SRC(NS)) i_lbus_irq_agg (
        .clk(clk), .rst_n(rst_n), .irq_lvl_i(lvl), .bus_we_i(we),
        .bus_addr_i(addr), .bus_size_i(size), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [31:0] exp_vec(input logic [15:0] s, input logic [15:0] m);
        logic [31:0] r;
        r = 0;
        for (int i = 15; i >= 0; i--) if (s[i] & m[i]) r = (i + 1) * 4;
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; size = sz; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [1:0] sz, output logic [31:0] d);
        addr = a; size = sz;
        #1;
        d = rdata;
    endtask

    task automatic set_lvl(input logic [15:0] v);
        @(negedge clk);
        lvl = v;
        @(negedge clk);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        logic [15:0] m, s;
        logic [31:0] st;
        st = 32'h1234_5678;

        // R5: reset state while request line 4 is high
        lvl = 16'h0010;
        repeat (4) @(negedge clk);
        check("R5 irq in reset", {31'b0, irq}, 0);
        rd(12'h002, 2'd1, r); check("R5 mask reset", r, 32'h0010);
        rd(12'h000, 2'd1, r); check("R5 vector reset", r, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 source sampled after reset", {31'b0, irq}, 1);
        rd(12'h000, 2'd1, r); check("R3 vector src4", r, 20);
        set_lvl(16'h0000);
        check("R1 level drop clears", {31'b0, irq}, 0);

        // R3: priority with all enabled and higher bits set as well
        wr(12'h002, 2'd1, 32'h0000_FFFF);
        for (int i = 0; i < 16; i++) begin
            set_lvl((16'hFFFF << i) & (16'h0001 << i | 16'hA5C3));
            rd(12'h000, 2'd1, r);
            check("R3 lowest wins", r, (i + 1) * 4);
        end

        // R2/R4: every enabled bit against every active line
        for (int mi = 0; mi < 16; mi++) begin
            wr(12'h002, 2'd1, 32'h0000_0001 << mi);
            rd(12'h002, 2'd1, r); check("R4 mask readback", r, 32'h1 << mi);
            for (int li = 0; li < 16; li++) begin
                set_lvl(16'h0001 << li);
                check("R2 single pair irq", {31'b0, irq}, (mi == li) ? 1 : 0);
                rd(12'h000, 2'd1, r);
                check("R3 single pair vector", r, (mi == li) ? (li + 1) * 4 : 0);
            end
        end

        // R2/R7: random patterns, word read gives {mask, vector}
        for (int k = 0; k < 200; k++) begin
            st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
            m = st[15:0]; s = st[31:16];
            wr(12'h002, 2'd1, {16'h0, m});
            set_lvl(s);
            check("R2 random irq", {31'b0, irq}, ((s & m) != 0) ? 1 : 0);
            rd(12'h000, 2'd2, r);
            check("R7 word read", r, {m, exp_vec(s, m)[15:0]});
        end

        // R2: mask change alone moves the output one edge later
        set_lvl(16'h0100);
        wr(12'h002, 2'd1, 32'h0000_0000);
        check("R2 masked off", {31'b0, irq}, 0);
        wr(12'h002, 2'd1, 32'h0000_0100);
        check("R2 mask enables", {31'b0, irq}, 1);

        // R6: byte lanes
        wr(12'h002, 2'd1, 32'h0000_1234);
        wr(12'h002, 2'd0, 32'hFFFF_FFAB);
        rd(12'h002, 2'd1, r); check("R6 low lane merge", r, 32'h12AB);
        wr(12'h003, 2'd0, 32'h0000_00CD);
        rd(12'h002, 2'd1, r); check("R6 high lane merge", r, 32'hCDAB);
        rd(12'h003, 2'd0, r); check("R6 byte read high", r, 32'hCD);
        rd(12'h002, 2'd0, r); check("R6 byte read low", r, 32'hAB);

        // R7: word writes at both positions
        wr(12'h000, 2'd2, 32'h5A5A_FFFF);
        rd(12'h002, 2'd1, r); check("R7 word write upper half", r, 32'h5A5A);
        wr(12'h002, 2'd3, 32'hEEEE_0F0F);
        rd(12'h002, 2'd1, r); check("R7 word write lower half", r, 32'h0F0F);

        // R8: ignored writes, zero reads
        wr(12'h000, 2'd1, 32'h0000_FFFF);
        rd(12'h002, 2'd1, r); check("R8 vector write ignored", r, 32'h0F0F);
        wr(12'h006, 2'd1, 32'h0000_0000);
        wr(12'h010, 2'd2, 32'h0000_0000);
        rd(12'h002, 2'd1, r); check("R8 undefined write ignored", r, 32'h0F0F);
        rd(12'h004, 2'd1, r); check("R8 undefined read zero", r, 0);
        rd(12'h010, 2'd2, r); check("R8 undefined word read", r, 0);
        rd(12'h002, 2'd2, r); check("R8 word over mask and hole", r, 32'h0000_0F0F);

        // R5: reset mid-run restores mask and clears sources
        lvl = 16'h0011;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R5 irq cleared by reset", {31'b0, irq}, 0);
        rd(12'h002, 2'd1, r); check("R5 mask restored", r, 32'h0010);
        rst_n = 1'b1;
        @(negedge clk);
        rd(12'h000, 2'd1, r); check("R5 vector after release", r, 20);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule